// File: doc/BRIEF.md
# Event Interrupt Aggregator with Read-Clear Sources

This block gathers twelve event sources from a two-wire serial bus controller into one raw status word. A host-programmable enable mask selects which of those bits may raise the single level-sensitive interrupt line. The event generators sit outside the block. Ten sources are edge events that the block latches. Two sources are FIFO level conditions that are shown directly.

A host reaches the block through a simple register port: a read strobe, a write strobe, a byte address, and data buses as wide as the source word. Read data is combinational and valid while the read strobe is high. Any side effect of a read takes place at the clock edge that ends the read cycle. A latched event is cleared by reading its own clear address. A read of one shared address clears every latched event at once. Nothing is cleared by writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the latched events and the mask are all zero and `irq_o` is low.
- R2: Source bits are: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Each is latched at the first clock edge that samples its input high after a low sample. An input that stays high does not set the bit again after it has been cleared.
- R3: Bit 2 (rx level reached) and bit 4 (tx empty) follow their inputs in the same cycle, are never latched, and no read clears them.
- R4: The mask register sits at offset 0x30, is 12 bits wide and reads back what was written. Writes to any other offset leave it unchanged.
- R5: A read at 0x34 returns the raw word. A read at 0x2C returns the raw word ANDed with the mask.
- R6: `irq_o` equals the OR of (raw AND mask) one clock later. With a zero mask it stays low even while raw bits are set.
- R7: A read at a per-source clear offset returns that source's current bit in bit 0, with 0 in all other bits, and clears only that bit. The offsets are 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10 and 0x68 bit 11.
- R8: A read at 0x40 returns, in bit 0, the OR of all latched bits, and clears all of them. The level bits are not affected.
- R9: When a rising input and a clearing read of the same bit fall in the same cycle, the bit ends up set.
- R10: A read at an unmapped offset returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | Event source inputs, one per status bit |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions check four things on every cycle:
- the one-cycle relation between the interrupt line and the masked raw word;
- the interrupt staying silent under a zero mask;
- the mask holding its value without a write to its offset;
- latched bits appearing only on rising inputs and vanishing after a global clear.

Other behaviour is only visible through the bench's directed scenarios, which a cycle-level reference model backs up:
- the read-back values of clear reads;
- the offset-to-bit mapping;
- set-over-clear priority;
- level bits surviving a clear;
- the silence of unmapped offsets.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC  = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam logic [N_SRC-1:0]  LEVEL_BITS = N_SRC'(12'h014);
  localparam logic [N_SRC-1:0]  LATCH_BITS = ~LEVEL_BITS;
  localparam int                N_CLR      = N_SRC - 2;
  localparam logic [ADDR_W-1:0] A_MSTAT    = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_RAW      = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_CLR_ALL  = ADDR_W'(8'h40);
  localparam int                A_CLR_BASE = 'h44;

  function automatic int src_of(input int k);
    return (k < 2) ? k : ((k == 2) ? 3 : k + 2);
  endfunction

  logic [N_SRC-1:0] evt_q, lat_q, mask_q, raw_w, rise_w, clr_sel;
  logic             clr_hit;

  assign rise_w = evt_i & ~evt_q;
  assign raw_w  = (lat_q & LATCH_BITS) | (evt_i & LEVEL_BITS);

  always_comb begin
    clr_sel = '0;
    clr_hit = 1'b0;
    if (bus_addr == A_CLR_ALL) begin
      clr_sel = LATCH_BITS;
      clr_hit = 1'b1;
    end
    for (int k = 0; k < N_CLR; k++) begin
      if (bus_addr == ADDR_W'(A_CLR_BASE + 4 * k)) begin
        clr_sel[src_of(k)] = 1'b1;
        clr_hit = 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_MSTAT: bus_rdata = raw_w & mask_q;
        A_MASK:  bus_rdata = mask_q;
        A_RAW:   bus_rdata = raw_w;
        default: bus_rdata = N_SRC'(clr_hit & |(lat_q & clr_sel));
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      lat_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      evt_q <= evt_i;
      lat_q <= ((lat_q & ~(clr_sel & {N_SRC{bus_rd}})) | rise_w) & LATCH_BITS;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
      irq_o <= |(raw_w & mask_q);
    end
  end
endmodule

module irq_aggregator_chk #(
  parameter int N_SRC  = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  evt,
  input logic [N_SRC-1:0]  evt_q,
  input logic [N_SRC-1:0]  lat,
  input logic [N_SRC-1:0]  raw,
  input logic [N_SRC-1:0]  mask,
  input logic              irq,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);
  logic [N_SRC-1:0] rise;
  assign rise = evt & ~evt_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(raw & mask)))); // R6
  AST_IRQ_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(8'h30)) |=> $stable(mask)); // R4
  AST_SET_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat & ~$past(lat) & ~$past(rise)) == '0)); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8'h40) && rise == '0) |=> (lat == '0)); // R8
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_i), .evt_q(evt_q), .lat(lat_q),
  .raw(raw_w), .mask(mask_q), .irq(irq_o), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic        irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  logic [11:0] m_lat = '0, m_prev = '0, m_mask = '0;
  logic        m_irq = 1'b0;

  function automatic logic [11:0] clr_of(input logic [7:0] a);
    case (a)
      8'h40: return 12'hFEB;
      8'h44: return 12'h001;  8'h48: return 12'h002;  8'h4C: return 12'h008;
      8'h50: return 12'h020;  8'h54: return 12'h040;  8'h58: return 12'h080;
      8'h5C: return 12'h100;  8'h60: return 12'h200;  8'h64: return 12'h400;
      8'h68: return 12'h800;
      default: return 12'h000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic [11:0] clr;
      clr = bus_rd ? clr_of(bus_addr) : 12'h000;
      m_irq  <= |((m_lat | (evt & 12'h014)) & m_mask);
      m_lat  <= ((m_lat & ~clr) | (evt & ~m_prev)) & 12'hFEB;
      m_prev <= evt;
      if (bus_wr && bus_addr == 8'h30) m_mask <= bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_o !== m_irq) begin
        failures++;
        $display("FAIL R6 irq per-cycle: actual=%0b expected=%0b", irq_o, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [11:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic pulse(input logic [11:0] b);
    @(negedge clk); evt = evt | b;
    @(negedge clk); evt = evt & ~b;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {11'd0, irq_o}, 12'h000);
    rd(8'h34, 12'h000, "R1 raw after reset");
    rd(8'h30, 12'h000, "R1 mask after reset");

    pulse(12'h040);
    rd(8'h34, 12'h040, "R2 tx abort latched");
    rd(8'h2C, 12'h000, "R5 masked with zero mask");
    chk("R6 irq low with zero mask", {11'd0, irq_o}, 12'h000);

    wr(8'h30, 12'hFFF);
    rd(8'h30, 12'hFFF, "R4 mask readback");
    wr(8'h34, 12'h123);
    rd(8'h30, 12'hFFF, "R4 stray write ignored");
    rd(8'h2C, 12'h040, "R5 masked status");
    chk("R6 irq high", {11'd0, irq_o}, 12'h001);

    rd(8'h54, 12'h001, "R7 clear read returns bit");
    rd(8'h34, 12'h000, "R7 tx abort cleared");

    pulse(12'h201);
    rd(8'h60, 12'h001, "R7 stop clear returns bit");
    rd(8'h34, 12'h001, "R7 other bits kept");
    rd(8'h60, 12'h000, "R7 second clear returns zero");

    @(negedge clk); evt = evt | 12'h014;
    rd(8'h34, 12'h015, "R3 level bits visible");
    rd(8'h40, 12'h001, "R8 global clear returns OR");
    rd(8'h34, 12'h014, "R8 level bits survive");
    rd(8'h50, 12'h000, "R3 level unaffected by clear read");
    @(negedge clk); evt = evt & ~12'h014;
    #1 chk("R3 level bits follow input", u_irq_aggregator.bus_rdata, 12'h000);
    rd(8'h34, 12'h000, "R3 level bits dropped");

    @(negedge clk); evt = evt | 12'h100;
    rd(8'h34, 12'h100, "R2 activity latched");
    rd(8'h5C, 12'h001, "R7 activity clear");
    rd(8'h34, 12'h000, "R2 held input no re-set");
    @(negedge clk); evt = evt & ~12'h100;

    @(negedge clk);
    evt = evt | 12'h800; bus_rd = 1'b1; bus_addr = 8'h68;
    #1 chk("R9 clear read before set", bus_rdata, 12'h000);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 8'h00; evt = evt & ~12'h800;
    rd(8'h34, 12'h800, "R9 set wins over clear");

    pulse(12'h002);
    rd(8'h3C, 12'h000, "R10 unmapped read zero");
    rd(8'h34, 12'h802, "R10 no side effect");
    rd(8'h48, 12'h001, "R7 rx overflow clear");

    wr(8'h30, 12'h000);
    repeat (2) @(negedge clk);
    chk("R6 zero mask silences irq", {11'd0, irq_o}, 12'h000);
    rd(8'h34, 12'h800, "R6 raw still set under zero mask");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule